// File: doc/BRIEF.md
# Dual-Input Gated Binary Counter

This block holds two identical, independent 4-bit binary up-counters. Each channel has two count inputs and a master clear. A rising edge on the first input (`rise_in`) advances the channel while the second input (`fall_in`) is high. A falling edge on `fall_in` advances the channel while `rise_in` is low. Either input can therefore serve as the count clock, with the other acting as its count enable. The count wraps from 15 to 0. A flag reports when a channel holds its all-ones value, for checking or for cascading.

All logic runs on one free-running system clock. The count, enable and clear inputs are taken to be asynchronous. Each one passes through a two-flop synchronizer, and edges are found by comparing each synchronized sample with the one before it. A high master clear drives the channel's outputs to zero at once through a combinational mask, and it clears the count register through the synchronized path. For a few cycles after the system reset is released, counting is held off so that input levels already present at start-up are not taken as edges.

Top module: `gated_dual_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every channel's count and full flag read 0 after that edge.
- R2: A low-to-high change on `rise_in[c]` while `fall_in[c]` is high advances channel c's count by exactly one.
- R3: A high-to-low change on `fall_in[c]` while `rise_in[c]` is low advances channel c's count by exactly one.
- R4: A rising `rise_in[c]` while `fall_in[c]` is low does not change the count. Neither does a falling `fall_in[c]` while `rise_in[c]` is high, a falling `rise_in[c]`, or a rising `fall_in[c]`.
- R5: A qualifying edge while the count is 15 gives a count of 0.
- R6: `full_out[c]` is 1 exactly when channel c's displayed count equals 15.
- R7: While `mclr_in[c]` is high, `count_out` for channel c reads 0 without waiting for any clock edge. Edges that occur while it is held are not counted, and input levels present at release are not counted as edges.
- R8: The count changes on the third rising clock edge after a qualifying input change. The first two edges load the synchronizer and the third edge updates the register.
- R9: Channels are independent: the inputs of one channel never change another channel's outputs. Channel c occupies `count_out[4c+3:4c]`.
- R10: Input levels present when `rst_n` is released are not counted. This includes `rise_in` and `fall_in` both high at release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| rise_in | input | NUM_CH | Per channel: counts on its rising edge while `fall_in` is high |
| fall_in | input | NUM_CH | Per channel: counts on its falling edge while `rise_in` is low |
| mclr_in | input | NUM_CH | Per channel: active-high master clear |
| count_out | output | NUM_CH*CNT_W | Packed channel counts, channel c at bits [CNT_W*c +: CNT_W] |
| full_out | output | NUM_CH | Per channel: count equals all ones |

## Verification
A qualifying edge on a count input shows up on `count_out` after the third rising clock edge. One test samples at the falling edge after the second clock edge and expects the old value, then samples after the third edge and expects the new value. The master clear mask is combinational, so the bench checks it 1 ns after driving `mclr_in`. Every other scenario holds each input level for four clock cycles, which covers the three-edge latency, and samples at falling edges so that no check races a register update.

// File: rtl/gdc_pkg.sv
// Shared types for the dual gated counter.
// Assumes: nothing beyond standard SystemVerilog packages.
package gdc_pkg;

    // Which qualifying condition produced a count step in a cycle.
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_RISE = 2'd1,
        STEP_FALL = 2'd2
    } step_src_e;

endpackage

// File: rtl/gdc_sync.sv
// Multi-bit level synchronizer: each bit is an independent flop chain.
// Assumes: bits are unrelated levels (no bus coherency needed), STAGES >= 2,
// and the inputs stay stable for at least one clock period per level.
module gdc_sync #(
    parameter int N      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    logic [STAGES-1:0][N-1:0] pipe_q;

    // Shift the sampled levels one stage deeper on every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                pipe_q[i] <= pipe_q[i-1];
            end
        end
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/gdc_edge_qual.sv
// Edge qualifier for one channel: finds a rising edge on the rise input
// gated by the fall input being high, or a falling edge on the fall input
// gated by the rise input being low. The history flops always follow the
// synchronized levels, including while a clear is active, so a release
// never shows a stale edge.
// Assumes: rise_lvl and fall_lvl are already synchronous to clk.
module gdc_edge_qual
    import gdc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rise_lvl,
    input  logic      fall_lvl,
    output step_src_e src
);

    logic rise_prev_q;
    logic fall_prev_q;

    // Remember the previous synchronized sample of both inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_prev_q <= 1'b0;
            fall_prev_q <= 1'b0;
        end else begin
            rise_prev_q <= rise_lvl;
            fall_prev_q <= fall_lvl;
        end
    end

    // Decide whether this sample carries a qualifying edge, and which kind.
    always_comb begin
        src = STEP_NONE;
        if (rise_lvl && !rise_prev_q && fall_lvl) begin
            src = STEP_RISE;
        end else if (fall_prev_q && !fall_lvl && !rise_lvl) begin
            src = STEP_FALL;
        end
    end

    // A step is only reported when at least one input actually changed.
    AST_STEP_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (src != STEP_NONE) |-> ((rise_lvl != rise_prev_q) || (fall_lvl != fall_prev_q))); // R4

endmodule

// File: rtl/gdc_counter.sv
// Count register for one channel, with wrap, master clear and full flag.
// clr_sync clears the register; clr_now masks the output at once.
// Assumes: clr_sync is the synchronized copy of clr_now.
module gdc_counter
    import gdc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_sync,
    input  logic         clr_now,
    input  logic         armed,
    input  step_src_e    src,
    output logic [W-1:0] value,
    output logic         full
);

    localparam logic [W-1:0] TOP_VAL = {W{1'b1}};
    localparam logic [W-1:0] ONE_VAL = W'(1);

    logic [W-1:0] cnt_q;
    logic         adv;

    // A step is taken only once the start-up window has passed.
    assign adv = armed && (src != STEP_NONE);

    // Clear wins over a step; at the top value a step wraps to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_sync) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= (cnt_q == TOP_VAL) ? '0 : cnt_q + ONE_VAL;
        end
    end

    // Mask the visible value while the raw clear is high and flag all ones.
    always_comb begin
        value = clr_now ? '0 : cnt_q;
        full  = (value == TOP_VAL);
    end

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_sync |=> (cnt_q == '0)); // R7
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_sync && adv) |=> (cnt_q == $past(cnt_q) + ONE_VAL)); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_sync && adv && (cnt_q == TOP_VAL)) |=> (cnt_q == '0)); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_sync && !adv) |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/gated_dual_counter.sv
// Top of the dual gated counter: synchronizes all channel inputs, holds
// off counting until the synchronizer has settled after reset, and
// instantiates one edge qualifier and one count register per channel.
// Assumes: rst_n is synchronous to clk; other inputs may be asynchronous.
module gated_dual_counter
    import gdc_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       rise_in,
    input  logic [NUM_CH-1:0]       fall_in,
    input  logic [NUM_CH-1:0]       mclr_in,
    output logic [NUM_CH*CNT_W-1:0] count_out,
    output logic [NUM_CH-1:0]       full_out
);

    localparam int SYNC_W  = 3 * NUM_CH;
    localparam int ARM_LEN = SYNC_STAGES + 1;

    logic [SYNC_W-1:0]  sync_bus;
    logic [NUM_CH-1:0]  rise_s;
    logic [NUM_CH-1:0]  fall_s;
    logic [NUM_CH-1:0]  mclr_s;
    logic [ARM_LEN-1:0] arm_q;
    logic               armed;

    gdc_sync #(
        .N      (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({mclr_in, fall_in, rise_in}),
        .dout  (sync_bus)
    );

    assign rise_s = sync_bus[NUM_CH-1:0];
    assign fall_s = sync_bus[2*NUM_CH-1:NUM_CH];
    assign mclr_s = sync_bus[3*NUM_CH-1:2*NUM_CH];

    // Fill a shift chain with ones after reset; count only once it is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= '0;
        end else begin
            arm_q <= {arm_q[ARM_LEN-2:0], 1'b1};
        end
    end

    assign armed = arm_q[ARM_LEN-1];

    AST_ARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (count_out == '0)); // R10

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        step_src_e src_w;

        gdc_edge_qual u_eq (
            .clk      (clk),
            .rst_n    (rst_n),
            .rise_lvl (rise_s[g]),
            .fall_lvl (fall_s[g]),
            .src      (src_w)
        );

        gdc_counter #(
            .W (CNT_W)
        ) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_sync (mclr_s[g]),
            .clr_now  (mclr_in[g]),
            .armed    (armed),
            .src      (src_w),
            .value    (count_out[g*CNT_W +: CNT_W]),
            .full     (full_out[g])
        );
    end

endmodule

// File: tb/gated_dual_counter_tb.sv
`timescale 1ns/1ps
module gated_dual_counter_tb;

    localparam int NCH = 2;
    localparam int W   = 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] rise_in;
    logic [NCH-1:0] fall_in;
    logic [NCH-1:0] mclr_in;
    logic [NCH*W-1:0] count_out;
    logic [NCH-1:0] full_out;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_cnt [NCH];
    bit finished = 0;

    always #10 clk = ~clk;

    gated_dual_counter u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_in   (rise_in),
        .fall_in   (fall_in),
        .mclr_in   (mclr_in),
        .count_out (count_out),
        .full_out  (full_out)
    );

    function automatic int cnt_of(int c);
        return int'(count_out[c*W +: W]);
    endfunction

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, int act, int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic chk_both(string tag);
        for (int c = 0; c < NCH; c++) begin
            chk(tag, cnt_of(c), exp_cnt[c]);
            chk(tag, int'(full_out[c]), (exp_cnt[c] == 15) ? 1 : 0);
        end
    endtask

    task automatic pulse_rise(int c);
        rise_in[c] = 1'b1; tick(4);
        rise_in[c] = 1'b0; tick(4);
    endtask

    task automatic pulse_fall(int c);
        fall_in[c] = 1'b0; tick(4);
        fall_in[c] = 1'b1; tick(4);
    endtask

    // R1 and R10: reset state, and no count from levels present at release.
    task automatic t_reset();
        rst_n = 1'b0; rise_in = '1; fall_in = '1; mclr_in = '0;
        tick(3);
        for (int c = 0; c < NCH; c++) exp_cnt[c] = 0;
        chk_both("R1 reset state");
        rst_n = 1'b1;
        tick(8);
        chk_both("R10 no count at reset release");
        rise_in = '0;
        tick(6);
        chk_both("R4 falling rise_in ignored");
    endtask

    // R8 and R2: exact cycle of the first count.
    task automatic t_latency();
        rise_in[0] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R8 not yet after two edges", cnt_of(0), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R8 R2 count after third edge", cnt_of(0), 1);
        exp_cnt[0] = 1;
        rise_in[0] = 1'b0; tick(4);
        chk_both("R2 hold after pulse");
    endtask

    // R2: several rising-clock counts on channel 0.
    task automatic t_rise_count();
        for (int i = 0; i < 3; i++) pulse_rise(0);
        exp_cnt[0] += 3;
        chk_both("R2 rise counting");
    endtask

    // R3 and R9: falling-clock counts on channel 1 only.
    task automatic t_fall_count();
        for (int i = 0; i < 2; i++) pulse_fall(1);
        exp_cnt[1] += 2;
        chk_both("R3 R9 fall counting");
    endtask

    // R4: disabled edges leave the count alone.
    task automatic t_gated_off();
        fall_in[0] = 1'b0; tick(4);          // qualifying fall, rise_in low
        exp_cnt[0] += 1;
        chk_both("R3 fall with rise_in low");
        pulse_rise(0);                       // fall_in low: disabled
        chk_both("R4 rise blocked by low fall_in");
        rise_in[0] = 1'b1; tick(4);
        fall_in[0] = 1'b1; tick(4);
        fall_in[0] = 1'b0; tick(4);          // rise_in high: disabled
        chk_both("R4 fall blocked by high rise_in");
        fall_in[0] = 1'b1; tick(4);
        rise_in[0] = 1'b0; tick(4);
        chk_both("R4 restore levels no count");
    endtask

    // R5 and R6: full flag and wrap on channel 0.
    task automatic t_wrap_full();
        while (exp_cnt[0] < 14) begin
            pulse_rise(0);
            exp_cnt[0]++;
        end
        chk_both("R6 full low at 14");
        pulse_rise(0); exp_cnt[0] = 15;
        chk_both("R6 full high at 15");
        pulse_rise(0); exp_cnt[0] = 0;
        chk_both("R5 wrap to zero");
    endtask

    // R7: immediate mask, edges ignored during clear, clean release.
    task automatic t_clear();
        mclr_in[1] = 1'b1;
        #1;
        chk("R7 immediate mask", cnt_of(1), 0);
        exp_cnt[1] = 0;
        tick(3);
        pulse_rise(1);
        pulse_rise(1);
        rise_in[1] = 1'b1; tick(4);
        mclr_in[1] = 1'b0; tick(6);
        chk_both("R7 no count during or at release");
        rise_in[1] = 1'b0; tick(4);
        pulse_rise(1); exp_cnt[1] = 1;
        chk_both("R7 counts again after clear");
    endtask

    // R9: clearing channel 0 leaves channel 1 untouched.
    task automatic t_independent();
        pulse_rise(0); pulse_rise(0); exp_cnt[0] = 2;
        mclr_in[0] = 1'b1; tick(4);
        exp_cnt[0] = 0;
        chk_both("R9 clear on channel 0 only");
        mclr_in[0] = 1'b0; tick(4);
        pulse_fall(1); exp_cnt[1] += 1;
        chk_both("R9 channel 1 independent");
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_latency();
        t_rise_count();
        t_fall_count();
        t_gated_off();
        t_wrap_full();
        t_clear();
        t_independent();
        finished = 1;
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
        end
    end

endmodule